// File: doc/BRIEF.md
# Paged Primary Slot Selector

This block steers every CPU memory cycle on a 16-bit address bus to one of four primary slots. The 64 KB space is cut into four 16 KB pages, and the two highest address bits name the page being touched (page 0 covers 0x0000-0x3FFF, page 1 0x4000-0x7FFF, page 2 0x8000-0xBFFF, page 3 0xC000-0xFFFF). An 8-bit mapping register holds a 2-bit slot number for each page. During a memory request, the field belonging to the current page drives exactly one of four slot-select lines.

Software programs the mapping through a single I/O port at address 0xA8. Only the low eight I/O address bits are compared. A write there loads the register on the next clock edge, so the very next memory cycle already follows the new mapping. A read returns the register unchanged. The register comes out of reset as 0x00, which puts every page on slot 0 so that boot code is visible at address zero. The block also exports the current register value and the page index of the present address.

Top module: `pslot_selector`

## Requirements
- R1: Output `page` always equals `addr[15:14]`.
- R2: The slot number for page p is register bits [2p+1:2p], so page 0 uses bits [1:0], page 1 uses [3:2], page 2 uses [5:4] and page 3 uses [7:6].
- R3: While `mem_req` is high, `slot_sel` is one-hot, and bit n is set where n is the slot number of the current page.
- R4: While `mem_req` is low, `slot_sel` is all zero. This includes every I/O cycle.
- R5: A cycle with `io_req` and `wr` high and `addr[7:0]` = 0xA8 loads `wdata` into the register at the next rising clock edge. `addr[15:8]` plays no part in the match.
- R6: An I/O write whose `addr[7:0]` is not 0xA8 leaves the register unchanged.
- R7: A cycle with `io_req` and `rd` high and `addr[7:0]` = 0xA8 shows the register contents, unmodified, on `rdata`. In every other cycle `rdata` is 0x00.
- R8: After reset, the register (seen on `slot_reg`) is 0x00, and a memory access to any page selects slot 0 (`slot_sel` = 4'b0001).
- R9: A memory write (`mem_req` and `wr` high, `io_req` low) never changes the register, even when `addr[7:0]` = 0xA8.
- R10: A memory access in the cycle right after a register write uses the newly written mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | input | 1 | Memory request strobe, active high |
| io_req | input | 1 | I/O request strobe, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Read data for the mapping port; zero when the port is not being read |
| slot_sel | output | 4 | One-hot primary slot select, valid during memory requests |
| slot_reg | output | 8 | Current mapping register value |
| page | output | 2 | Page index of the current address |

## Verification
The bench writes a mapping with a different slot in every page and then sweeps all four pages. A design that reads the wrong bit pair, or swaps the order of the pages, selects the wrong line there. It sends writes whose upper address byte is non-zero, writes to a neighbouring port, and memory writes to address 0xA8. A decoder that compares too many bits, accepts near misses, or ignores the I/O strobe either drops a valid update or corrupts the mapping. A memory access is placed right after each write, and I/O cycles are mixed with memory cycles, which shows any mapping that lags by a cycle and any select that leaks outside memory requests.

// File: rtl/pslot_pkg.sv
package pslot_pkg;

   // Default geometry of the slot selector
   localparam int unsigned PSL_ADDR_W    = 16;
   localparam int unsigned PSL_PAGE_W    = 2;
   localparam int unsigned PSL_SLOT_W    = 2;
   localparam int unsigned PSL_IO_DEC_W  = 8;
   localparam logic [15:0] PSL_IO_PORT   = 16'h00A8;

   // Kind of bus cycle seen by the selector
   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,
      CYC_MEM  = 2'd1,
      CYC_IO   = 2'd2,
      CYC_BOTH = 2'd3
   } cyc_kind_e;

   function automatic cyc_kind_e classify(input logic mem_req, input logic io_req);
      return cyc_kind_e'({io_req, mem_req});
   endfunction

endpackage

// File: rtl/pslot_io_decode.sv
module pslot_io_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned IO_DEC_W = 8,
   parameter logic [ADDR_W-1:0] IO_PORT = 16'h00A8
) (
   input  logic              io_req,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_hit,
   output logic              rd_hit
);
   import pslot_pkg::*;

   initial begin
      if (IO_DEC_W == 0 || IO_DEC_W > ADDR_W)
         $error("pslot_io_decode: IO_DEC_W must be 1..ADDR_W");
   end

   logic port_match;
   cyc_kind_e kind;

   assign kind = classify(1'b0, io_req);

   generate
      if (IO_DEC_W == ADDR_W) begin : g_full_dec
         assign port_match = (addr == IO_PORT);
      end else begin : g_part_dec
         assign port_match = (addr[IO_DEC_W-1:0] == IO_PORT[IO_DEC_W-1:0]);
      end
   endgenerate

   assign wr_hit = (kind == CYC_IO) && wr && port_match;
   assign rd_hit = (kind == CYC_IO) && rd && port_match;

endmodule

// File: rtl/pslot_map_reg.sv
module pslot_map_reg #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   initial begin
      if (DATA_W == 0)
         $error("pslot_map_reg: DATA_W must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET_VAL;
      else if (load)
         q <= wdata;
   end

   AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(wdata)));                                // R5
   AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));                                         // R6

endmodule

// File: rtl/pslot_page_map.sv
module pslot_page_map #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned PAGE_W = 2,
   parameter int unsigned SLOT_W = 2,
   localparam int unsigned NUM_PAGES = 1 << PAGE_W,
   localparam int unsigned NUM_SLOTS = 1 << SLOT_W,
   localparam int unsigned REG_W     = NUM_PAGES * SLOT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mem_req,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [REG_W-1:0]     map,
   output logic [PAGE_W-1:0]    page,
   output logic [NUM_SLOTS-1:0] slot_sel
);

   initial begin
      if (PAGE_W == 0 || PAGE_W >= ADDR_W)
         $error("pslot_page_map: PAGE_W out of range");
      if (SLOT_W == 0)
         $error("pslot_page_map: SLOT_W must be non-zero");
   end

   logic [SLOT_W-1:0] field [NUM_PAGES];
   logic [SLOT_W-1:0] cur_slot;

   assign page = addr[ADDR_W-1 -: PAGE_W];

   generate
      for (genvar p = 0; p < NUM_PAGES; p++) begin : g_field
         assign field[p] = map[p*SLOT_W +: SLOT_W];
      end
   endgenerate

   assign cur_slot = field[page];

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
         assign slot_sel[s] = mem_req && (cur_slot == SLOT_W'(s));
      end
   endgenerate

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(slot_sel) == 1));                      // R3
   AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> (slot_sel == '0));                                // R4

endmodule

// File: rtl/pslot_selector.sv
module pslot_selector #(
   parameter int unsigned ADDR_W   = pslot_pkg::PSL_ADDR_W,
   parameter int unsigned PAGE_W   = pslot_pkg::PSL_PAGE_W,
   parameter int unsigned SLOT_W   = pslot_pkg::PSL_SLOT_W,
   parameter int unsigned IO_DEC_W = pslot_pkg::PSL_IO_DEC_W,
   parameter logic [ADDR_W-1:0] IO_PORT = pslot_pkg::PSL_IO_PORT,
   localparam int unsigned NUM_SLOTS = 1 << SLOT_W,
   localparam int unsigned DATA_W    = (1 << PAGE_W) * SLOT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mem_req,
   input  logic                 io_req,
   input  logic                 rd,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic [NUM_SLOTS-1:0] slot_sel,
   output logic [DATA_W-1:0]    slot_reg,
   output logic [PAGE_W-1:0]    page
);

   logic wr_hit;
   logic rd_hit;

   pslot_io_decode #(
      .ADDR_W   (ADDR_W),
      .IO_DEC_W (IO_DEC_W),
      .IO_PORT  (IO_PORT)
   ) u_io_decode (
      .io_req (io_req),
      .rd     (rd),
      .wr     (wr),
      .addr   (addr),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   pslot_map_reg #(
      .DATA_W    (DATA_W),
      .RESET_VAL ('0)
   ) u_map_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_hit),
      .wdata (wdata),
      .q     (slot_reg)
   );

   pslot_page_map #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .SLOT_W (SLOT_W)
   ) u_page_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .mem_req  (mem_req),
      .addr     (addr),
      .map      (slot_reg),
      .page     (page),
      .slot_sel (slot_sel)
   );

   assign rdata = rd_hit ? slot_reg : '0;

   AST_RD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && rd && addr[IO_DEC_W-1:0] == IO_PORT[IO_DEC_W-1:0])
      |-> (rdata == slot_reg));                                      // R7
   AST_MEMWR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_req) |=> $stable(slot_reg));                              // R9

endmodule

// File: tb/pslot_selector_tb.sv
module pslot_selector_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req = 1'b0, io_req = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [3:0]  slot_sel;
   logic [7:0]  slot_reg;
   logic [1:0]  page;

   int compared = 0;
   int mismatched = 0;
   int ref_map = 0;

   always #10 clk = ~clk;

   pslot_selector u_dut (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .io_req(io_req),
      .rd(rd), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
      .slot_sel(slot_sel), .slot_reg(slot_reg), .page(page)
   );

   task automatic check(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // One bus cycle: drive after the falling edge, compare before the rising edge,
   // then advance the reference model past the edge.
   task automatic cyc(input bit m, input bit io, input bit r, input bit w,
                      input int a, input int d, input string tag);
      int pg, fld, exp_sel, exp_rd;
      @(negedge clk);
      mem_req = m; io_req = io; rd = r; wr = w;
      addr = a[15:0]; wdata = d[7:0];
      #5;
      pg = (a >> 14) & 3;
      fld = (ref_map >> (2 * pg)) & 3;
      exp_sel = m ? (1 << fld) : 0;
      exp_rd = (io && r && ((a & 8'hFF) == 8'hA8)) ? ref_map : 0;
      check({tag, "/R1 page"}, int'(page), pg);
      check({tag, "/R2 R3 R4 slot_sel"}, int'(slot_sel), exp_sel);
      check({tag, "/R7 rdata"}, int'(rdata), exp_rd);
      check({tag, "/R5 R6 R9 slot_reg"}, int'(slot_reg), ref_map);
      if (io && w && ((a & 8'hFF) == 8'hA8)) ref_map = d & 8'hFF;
   endtask

   initial begin
      #(20 * 200000);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      // R8: reset state, every page on slot 0
      check("R8 reset slot_reg", int'(slot_reg), 0);
      for (int p = 0; p < 4; p++) cyc(1, 0, 1, 0, p << 14 | 16'h0123, 0, "R8");
      // R4: I/O cycles select no slot
      cyc(0, 1, 1, 0, 16'hC0A8, 0, "R4 io read");
      // R5 R10 R2: distinct slot per page, then sweep pages right away
      cyc(0, 1, 0, 1, 16'h00A8, 8'hE4, "R5 write E4");
      for (int p = 0; p < 4; p++) cyc(1, 0, 1, 0, p << 14 | 16'h2000, 0, "R10 R2 sweep");
      check("R2 page3 slot3", int'(slot_sel), 8);
      // R5: upper address bits ignored
      cyc(0, 1, 0, 1, 16'h5AA8, 8'h1B, "R5 upper bits");
      cyc(1, 0, 0, 0, 16'h0000, 0, "R10 after write");
      check("R5 slot_reg 1B", int'(slot_reg), 8'h1B);
      // R6: neighbouring ports ignored
      cyc(0, 1, 0, 1, 16'h00A9, 8'hFF, "R6 port A9");
      cyc(0, 1, 0, 1, 16'h00A0, 8'hFF, "R6 port A0");
      cyc(0, 1, 1, 0, 16'h00A8, 0, "R6 R7 readback");
      // R9: memory write to 0x00A8 ignored
      cyc(1, 0, 0, 1, 16'h00A8, 8'h55, "R9 mem write");
      cyc(1, 0, 1, 0, 16'hFFFF, 0, "R9 after");
      check("R9 slot_reg kept", int'(slot_reg), 8'h1B);
      // R7: read with non-matching port yields zero
      cyc(0, 1, 1, 0, 16'h01A7, 0, "R7 miss");
      // Random mix
      for (int i = 0; i < 3000; i++) begin
         int kind;
         int a;
         kind = $urandom_range(0, 3);
         a = $urandom_range(0, 65535);
         if ($urandom_range(0, 3) == 0) a = (a & 16'hFF00) | 16'h00A8;
         cyc(kind == 0 || kind == 3, kind == 1 || kind == 2,
             $urandom_range(0, 1), $urandom_range(0, 1), a,
             $urandom_range(0, 255), "rand");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule